// File: doc/BRIEF.md
# Inverted-Encoding Register PWM Generator

This block is a single-channel pulse-width modulator steered by one 32-bit control word written over a plain register bus. The word carries three fields: a run-enable flag, an 8-bit clock divider and an 8-bit duty code. The divider sets how many input clocks make up one count step, and one output period is always 256 steps long.

The duty code is inverted and taken modulo 256. A larger code gives a shorter high time. A code of 1 keeps the output high for 255 of the 256 steps, and a code of 255 gives a single high step. A code of 0 stands for 256, so the output stays low for the whole period.

New divider or duty values written while the block is running are held back until the running period ends, so the output never shows a clipped pulse. Software can read the word back at any time, with the unused bits returning zero.

Top module: `pwm_inv_duty`

## Requirements
- R1: A synchronous active-high reset clears the control word, so bus_rdata reads 0, and holds pwm_out low.
- R2: In the control word, bit 31 is the enable, bits 15:8 are the divider and bits 7:0 are the duty code. A write appears on bus_rdata in the cycle after the write edge, and all other bits read as zero.
- R3: With a duty code d from 1 to 255, pwm_out is high for the first 256-d steps of each 256-step period and low for the rest. For example, d=1 gives 255 high steps, d=128 gives 128 and d=255 gives 1.
- R4: A duty code of 0 keeps pwm_out low for the entire period.
- R5: A divider value N from 1 to 255 makes each step last N input clocks, so a period lasts 256*N clocks.
- R6: A divider value of 0 makes each step last 256 input clocks.
- R7: While the enable bit reads 0, pwm_out is low, starting in the cycle after the write that clears the bit, and the counters are held at zero. After a write that sets the enable, the first period starts with step 0 on the second clock edge after the write.
- R8: Divider or duty values written while the block is running take effect only at the next period boundary. The running period finishes with its old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_we | input | 1 | Write strobe for the control word |
| bus_wdata | input | 32 | Write data for the control word |
| bus_rdata | output | 32 | Read-back of the control word |
| pwm_out | output | 1 | Modulated output |

## Verification
Read-back is due one cycle after the write edge. A cleared enable forces the output low in that same cycle. A set enable starts step 0 after the second edge, and the first sample taken then is the first cycle of the period. The bench keeps a behavioural model that follows this cycle timing and compares both outputs against it on every falling edge. It also counts high cycles over windows of exactly one period, which start at that second edge. For the deferred-update case, the count runs across a write made in the middle of a period, and the new setting must show only in the following window.

// File: rtl/pwm_inv_pkg.sv
package pwm_inv_pkg;

   // Width of the step counter, prescaler and both fields
   localparam int CNT_W = 8;
   localparam int STEPS = 1 << CNT_W;

   typedef logic [CNT_W-1:0] cnt_t;
   typedef logic [CNT_W:0]   span_t;

   typedef struct packed {
      logic en;
      cnt_t reload;
      cnt_t duty;
   } ctrl_t;

   // Number of high steps for a duty code; code 0 stands for STEPS
   function automatic span_t high_span(cnt_t duty);
      if (duty == '0) return '0;
      return span_t'(STEPS) - span_t'(duty);
   endfunction

endpackage

// File: rtl/pwm_inv_regs.sv
module pwm_inv_regs
   import pwm_inv_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int EN_BIT     = 31,
   parameter int RELOAD_LSB = 8,
   parameter int DUTY_LSB   = 0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output ctrl_t             ctrl_q,
   output logic [DATA_W-1:0] rd_data
);

   localparam int RELOAD_MSB = RELOAD_LSB + CNT_W - 1;
   localparam int DUTY_MSB   = DUTY_LSB + CNT_W - 1;

   // Elaboration checks on field placement
   if (EN_BIT >= DATA_W || RELOAD_MSB >= DATA_W || DUTY_MSB >= DATA_W) begin : g_bad_fit
      $error("pwm_inv_regs: a field lies outside the data word");
   end
   if (RELOAD_LSB <= DUTY_MSB && DUTY_LSB <= RELOAD_MSB) begin : g_bad_overlap
      $error("pwm_inv_regs: divider and duty fields overlap");
   end
   if ((EN_BIT >= RELOAD_LSB && EN_BIT <= RELOAD_MSB) ||
       (EN_BIT >= DUTY_LSB && EN_BIT <= DUTY_MSB)) begin : g_bad_en
      $error("pwm_inv_regs: enable bit lies inside a field");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ctrl_q <= '0;
      end else if (wr_en) begin
         ctrl_q.en     <= wr_data[EN_BIT];
         ctrl_q.reload <= wr_data[RELOAD_LSB +: CNT_W];
         ctrl_q.duty   <= wr_data[DUTY_LSB +: CNT_W];
      end
   end

   always_comb begin
      rd_data                       = '0;
      rd_data[EN_BIT]               = ctrl_q.en;
      rd_data[RELOAD_LSB +: CNT_W]  = ctrl_q.reload;
      rd_data[DUTY_LSB +: CNT_W]    = ctrl_q.duty;
   end

   logic unused_wr_bits;
   assign unused_wr_bits = ^wr_data;

endmodule

// File: rtl/pwm_inv_timebase.sv
module pwm_inv_timebase
   import pwm_inv_pkg::*;
(
   input  logic  clk,
   input  logic  rst,
   input  ctrl_t ctrl_q,
   output logic  run_q,
   output cnt_t  act_reload,
   output cnt_t  act_duty,
   output cnt_t  step_q,
   output logic  tick,
   output logic  boundary
);

   cnt_t pre_q;
   logic running;
   cnt_t pre_last;

   assign running  = ctrl_q.en & run_q;
   // Divider 0 wraps to the last count, giving STEPS clocks per step
   assign pre_last = cnt_t'(act_reload - cnt_t'(1));
   assign tick     = running & (pre_q == pre_last);
   assign boundary = tick & (step_q == '1);

   always_ff @(posedge clk) begin
      if (rst) begin
         run_q      <= 1'b0;
         pre_q      <= '0;
         step_q     <= '0;
         act_reload <= '0;
         act_duty   <= '0;
      end else begin
         run_q <= ctrl_q.en;
         if (!running) begin
            pre_q  <= '0;
            step_q <= '0;
         end else if (tick) begin
            pre_q  <= '0;
            step_q <= step_q + cnt_t'(1);
         end else begin
            pre_q  <= pre_q + cnt_t'(1);
         end
         if (!run_q || boundary) begin
            act_reload <= ctrl_q.reload;
            act_duty   <= ctrl_q.duty;
         end
      end
   end

endmodule

// File: rtl/pwm_inv_compare.sv
module pwm_inv_compare
   import pwm_inv_pkg::*;
(
   input  logic en,
   input  logic run_q,
   input  cnt_t act_duty,
   input  cnt_t step_q,
   output logic pwm_o
);

   span_t span;

   assign span  = high_span(act_duty);
   assign pwm_o = en & run_q & (span_t'(step_q) < span);

endmodule

// File: rtl/pwm_inv_duty.sv
module pwm_inv_duty
   import pwm_inv_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int EN_BIT     = 31,
   parameter int RELOAD_LSB = 8,
   parameter int DUTY_LSB   = 0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              pwm_out
);

   ctrl_t ctrl_q;
   logic  run_q;
   cnt_t  act_reload;
   cnt_t  act_duty;
   cnt_t  step_q;
   logic  tick;
   logic  boundary;

   pwm_inv_regs #(
      .DATA_W     (DATA_W),
      .EN_BIT     (EN_BIT),
      .RELOAD_LSB (RELOAD_LSB),
      .DUTY_LSB   (DUTY_LSB)
   ) u_regs (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (bus_we),
      .wr_data (bus_wdata),
      .ctrl_q  (ctrl_q),
      .rd_data (bus_rdata)
   );

   pwm_inv_timebase u_time (
      .clk        (clk),
      .rst        (rst),
      .ctrl_q     (ctrl_q),
      .run_q      (run_q),
      .act_reload (act_reload),
      .act_duty   (act_duty),
      .step_q     (step_q),
      .tick       (tick),
      .boundary   (boundary)
   );

   pwm_inv_compare u_cmp (
      .en       (ctrl_q.en),
      .run_q    (run_q),
      .act_duty (act_duty),
      .step_q   (step_q),
      .pwm_o    (pwm_out)
   );

endmodule

// File: rtl/pwm_inv_chk.sv
module pwm_inv_chk #(
   parameter int DATA_W     = 32,
   parameter int EN_BIT     = 31,
   parameter int RELOAD_LSB = 8,
   parameter int DUTY_LSB   = 0
) (
   input logic              clk,
   input logic              rst,
   input logic              bus_we,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              pwm_out,
   input logic              run_q,
   input logic [7:0]        act_duty,
   input logic [7:0]        step_q,
   input logic              tick,
   input logic              boundary
);

   localparam logic [DATA_W-1:0] FIELD_MASK =
      (DATA_W'(1) << EN_BIT) | (DATA_W'(8'hFF) << RELOAD_LSB) | (DATA_W'(8'hFF) << DUTY_LSB);

   logic rst_d;

   always_ff @(posedge clk) begin
      rst_d <= rst;
      if (rst_d) begin
         assert_reset_state_R1: assert (bus_rdata == '0 && !pwm_out);
      end
   end

   assert_write_visible_R2: assert property (@(posedge clk) disable iff (rst)
      bus_we |=> (bus_rdata == ($past(bus_wdata) & FIELD_MASK)));

   assert_duty_zero_low_R4: assert property (@(posedge clk) disable iff (rst)
      (act_duty == 8'd0) |-> !pwm_out);

   assert_step_hold_R5: assert property (@(posedge clk) disable iff (rst)
      (run_q && bus_rdata[EN_BIT] && !tick) |=> $stable(step_q));

   assert_disabled_low_R7: assert property (@(posedge clk) disable iff (rst)
      !bus_rdata[EN_BIT] |-> !pwm_out);

   assert_shadow_hold_R8: assert property (@(posedge clk) disable iff (rst)
      (run_q && !boundary) |=> $stable(act_duty));

endmodule

bind pwm_inv_duty pwm_inv_chk #(
   .DATA_W     (DATA_W),
   .EN_BIT     (EN_BIT),
   .RELOAD_LSB (RELOAD_LSB),
   .DUTY_LSB   (DUTY_LSB)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .bus_we    (bus_we),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .pwm_out   (pwm_out),
   .run_q     (run_q),
   .act_duty  (act_duty),
   .step_q    (step_q),
   .tick      (tick),
   .boundary  (boundary)
);

// File: tb/pwm_inv_duty_tb.sv
module pwm_inv_duty_tb;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        pwm_out;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #2 clk = ~clk;   // 250 MHz

   pwm_inv_duty u_dut (
      .clk       (clk),
      .rst       (rst),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pwm_out   (pwm_out)
   );

   task automatic check(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Behavioural reference model, advanced on each rising edge
   int m_en = 0, m_rl = 0, m_dt = 0, m_run = 0;
   int m_srl = 0, m_sdt = 0, m_pre = 0, m_step = 0;
   int m_div;
   bit m_going, m_tick, m_bnd;

   always @(posedge clk) begin
      if (rst) begin
         m_en = 0; m_rl = 0; m_dt = 0; m_run = 0;
         m_srl = 0; m_sdt = 0; m_pre = 0; m_step = 0;
      end else begin
         m_going = (m_en != 0) && (m_run != 0);
         m_div   = (m_srl == 0) ? 256 : m_srl;
         m_tick  = m_going && (m_pre == m_div - 1);
         m_bnd   = m_tick && (m_step == 255);
         if (m_run == 0 || m_bnd) begin
            m_srl = m_rl;
            m_sdt = m_dt;
         end
         if (!m_going) begin
            m_pre = 0; m_step = 0;
         end else if (m_tick) begin
            m_pre = 0; m_step = (m_step + 1) % 256;
         end else begin
            m_pre = m_pre + 1;
         end
         m_run = m_en;
         if (bus_we) begin
            m_en = int'(bus_wdata[31]);
            m_rl = int'(bus_wdata[15:8]);
            m_dt = int'(bus_wdata[7:0]);
         end
      end
   end

   function automatic int model_out();
      int hi;
      hi = (m_sdt == 0) ? 0 : 256 - m_sdt;
      return (m_en != 0 && m_run != 0 && m_step < hi) ? 1 : 0;
   endfunction

   // Per-cycle comparison against the model
   always @(negedge clk) begin
      if (!rst && !done) begin
         check("R3 per-cycle pwm_out", longint'(pwm_out), longint'(model_out()));
         check("R2 per-cycle rdata", longint'(bus_rdata),
               longint'((m_en << 31) | (m_rl << 8) | m_dt));
      end
   end

   function automatic logic [31:0] mk(input bit en, input int rl, input int dt);
      return {en, 15'd0, 8'(rl), 8'(dt)};
   endfunction

   task automatic wr(input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1;
      bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic count_high(input int n, output int h);
      h = 0;
      repeat (n) begin
         @(negedge clk);
         if (pwm_out) h++;
      end
   endtask

   task automatic stop_and_check_low();
      wr(32'd0);
      check("R7 low after disable", longint'(pwm_out), 0);
      repeat (4) begin
         @(negedge clk);
         check("R7 low while disabled", longint'(pwm_out), 0);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int h;
      int duties[6] = '{1, 25, 128, 220, 255, 0};
      repeat (3) @(negedge clk);
      check("R1 reset pwm_out", longint'(pwm_out), 0);
      check("R1 reset rdata", longint'(bus_rdata), 0);
      rst = 1'b0;

      // R2: read-back masking
      wr(32'hFFFF_FFFF);
      check("R2 readback mask", longint'(bus_rdata), longint'(32'h8000_FFFF));
      stop_and_check_low();
      check("R2 readback cleared", longint'(bus_rdata), 0);

      // R3 / R4: duty codes with divider 1
      foreach (duties[i]) begin
         wr(mk(1, 1, duties[i]));
         count_high(256, h);
         check(duties[i] == 0 ? "R4 duty zero high count" : "R3 high count",
               h, duties[i] == 0 ? 0 : 256 - duties[i]);
         stop_and_check_low();
      end

      // R5: divider 3, duty 64
      wr(mk(1, 3, 64));
      count_high(768, h);
      check("R5 divider 3 high count", h, 192 * 3);
      count_high(768, h);
      check("R5 divider 3 second period", h, 192 * 3);
      stop_and_check_low();

      // R6: divider 0 means 256 clocks per step
      wr(mk(1, 0, 192));
      count_high(65536, h);
      check("R6 divider 0 high count", h, 64 * 256);
      stop_and_check_low();

      // R8: duty change in mid-period waits for boundary
      wr(mk(1, 1, 128));
      h = 0;
      for (int i = 0; i < 256; i++) begin
         @(negedge clk);
         if (pwm_out) h++;
         if (i == 99) begin
            bus_we = 1'b1;
            bus_wdata = mk(1, 1, 255);
         end else begin
            bus_we = 1'b0;
         end
      end
      check("R8 old duty finishes period", h, 128);
      count_high(256, h);
      check("R8 new duty next period", h, 1);

      // R7: disable then re-enable restarts at step 0
      stop_and_check_low();
      wr(mk(1, 1, 128));
      count_high(256, h);
      check("R7 restart full period", h, 128);
      stop_and_check_low();

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule